// File: doc/BRIEF.md
# Address-Value Delta Load Value Predictor

This block learns, for each load instruction, the arithmetic gap between the address the load reads and the value it returns. Loads that walk linked structures often return a pointer that sits a fixed distance from the address they were read from. When such a load sees the same gap on repeated executions, the block can supply a value for it: the load's own address minus the learned gap.

A small fully associative table, keyed by the load's program counter, is trained from loads that complete with real data. Each entry has a signed gap and a two-bit confidence counter. A separate lookup port takes a load's program counter and address, plus two qualifiers: the load missed to far memory, and the core is pre-executing ahead of a stalled miss. A predicted value is offered only when both qualifiers are set and the entry is confident. The lookup is combinational. A training update is visible from the next clock edge. Loads whose gap is too large to be a pointer offset never claim an entry.

Top module: `avd_predictor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the table, so that no lookup is predicted until new training has taken place.
- R2: The gap learned from a training load is `trn_addr - trn_data` modulo 2^ADDR_W. A prediction returns `prd_addr - gap` modulo 2^ADDR_W, and a negative gap (data above address) works the same way.
- R3: `prd_valid` is high only when `prd_req`, `prd_long_miss` and `prd_runahead` are all high, `prd_pc` matches a valid entry, and that entry's confidence is 2 or more.
- R4: A training load whose program counter hits an entry and whose gap equals the stored gap raises the confidence by one, saturating at 3. A newly allocated entry therefore needs two further matching loads before it predicts.
- R5: A training load that hits an entry with a different gap replaces the stored gap and sets the confidence to 0.
- R6: The table is unchanged in a cycle where `trn_valid` is low or `trn_from_pred` is high (a load served by a prediction).
- R7: A training load that misses takes the lowest-numbered empty entry. If no entry is empty, it takes the entry least recently touched by a training hit or an allocation. Lookups do not change recency. A new entry starts at confidence 0.
- R8: On a training miss, a gap whose two's-complement magnitude exceeds DELTA_MAX (default 0x10000) allocates nothing. A gap of exactly ±DELTA_MAX is allocated.
- R9: A lookup in the same cycle as a training load reads the table as it stood before that training load. The update is seen from the following cycle.
- R10: While `prd_valid` is low, `prd_value` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trn_valid | input | 1 | A completed load is presented for training |
| trn_pc | input | PC_W | Program counter of the training load |
| trn_addr | input | ADDR_W | Effective address of the training load |
| trn_data | input | ADDR_W | Value returned by the training load |
| trn_from_pred | input | 1 | The training load was served by a prediction; suppresses training |
| prd_req | input | 1 | A lookup is requested |
| prd_pc | input | PC_W | Program counter of the load being looked up |
| prd_addr | input | ADDR_W | Effective address of the load being looked up |
| prd_long_miss | input | 1 | The load missed to far memory |
| prd_runahead | input | 1 | The core is in pre-execution mode |
| prd_valid | output | 1 | A predicted value is offered |
| prd_value | output | ADDR_W | Predicted value, zero when not valid |

## Verification
The bench targets these corner cases:
- **Confidence threshold.** A design that predicts after one matching repeat shows up on the lookup between the second and third training loads.
- **Reset of a changed gap.** A design that only decrements the confidence, instead of clearing it, keeps predicting with the stale gap.
- **Replacement.** A full table is made to evict after one old entry has been refreshed. An LRU error, or a lookup that updates recency, evicts the wrong program counter, which then keeps or loses its prediction against the reference.
- **Gap filter.** It is probed just inside and just outside ±DELTA_MAX. Gap arithmetic that wraps negative gaps is exposed by predicting with a gap whose data lies above its address.

// File: rtl/avd_pkg.sv
`timescale 1ns/1ps
package avd_pkg;

    typedef logic [1:0] conf_t;

    localparam conf_t CONF_MAX = 2'd3;

    function automatic conf_t conf_inc(input conf_t c);
        return (c == CONF_MAX) ? c : c + 2'd1;
    endfunction

endpackage

// File: rtl/avd_cam.sv
`timescale 1ns/1ps
module avd_cam #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]           vld,
    input  logic [ENTRIES-1:0][PC_W-1:0] tags,
    input  logic [PC_W-1:0]              key,
    output logic [ENTRIES-1:0]           hit_vec,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/avd_age.sv
`timescale 1ns/1ps
module avd_age #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);

    typedef logic [IDX_W-1:0] age_t;

    age_t age_q [ENTRIES];
    age_t age_d [ENTRIES];
    age_t touched_age;

    always_comb begin
        touched_age = age_q[touch_idx];
        victim_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            age_d[i] = age_q[i];
            if (touch) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_d[i] = '0;
                end else if (age_q[i] < touched_age) begin
                    age_d[i] = age_q[i] + age_t'(1);
                end
            end
            if (age_q[i] == age_t'(ENTRIES - 1)) begin
                victim_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                age_q[i] <= age_t'(i);
            end else begin
                age_q[i] <= age_d[i];
            end
        end
    end

endmodule

// File: rtl/avd_predictor.sv
`timescale 1ns/1ps
module avd_predictor
    import avd_pkg::*;
#(
    parameter int                ENTRIES   = 16,
    parameter int                PC_W      = 32,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] DELTA_MAX = 'h10000,
    parameter int                CONF_THR  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trn_valid,
    input  logic [PC_W-1:0]   trn_pc,
    input  logic [ADDR_W-1:0] trn_addr,
    input  logic [ADDR_W-1:0] trn_data,
    input  logic              trn_from_pred,
    input  logic              prd_req,
    input  logic [PC_W-1:0]   prd_pc,
    input  logic [ADDR_W-1:0] prd_addr,
    input  logic              prd_long_miss,
    input  logic              prd_runahead,
    output logic              prd_valid,
    output logic [ADDR_W-1:0] prd_value
);

    localparam int IDX_W = $clog2(ENTRIES);

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic              vld;
        logic [PC_W-1:0]   tag;
        logic [ADDR_W-1:0] delta;
        conf_t             conf;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } state_t;

    state_t st_q, st_d;

    logic [ENTRIES-1:0]           vld_vec;
    logic [ENTRIES-1:0][PC_W-1:0] tag_arr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_fields
        assign vld_vec[g] = st_q.ent[g].vld;
        assign tag_arr[g] = st_q.ent[g].tag;
    end

    logic [ENTRIES-1:0] t_hit_vec, p_hit_vec;
    logic               t_hit, p_hit;
    idx_t               t_idx, p_idx;
    idx_t               victim_idx;
    logic               touch;
    idx_t               touch_idx;

    avd_cam #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_trn_cam (
        .vld    (vld_vec),
        .tags   (tag_arr),
        .key    (trn_pc),
        .hit_vec(t_hit_vec),
        .hit    (t_hit),
        .hit_idx(t_idx)
    );

    avd_cam #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_prd_cam (
        .vld    (vld_vec),
        .tags   (tag_arr),
        .key    (prd_pc),
        .hit_vec(p_hit_vec),
        .hit    (p_hit),
        .hit_idx(p_idx)
    );

    avd_age #(.ENTRIES(ENTRIES)) u_age (
        .clk       (clk),
        .rst       (rst),
        .touch     (touch),
        .touch_idx (touch_idx),
        .victim_idx(victim_idx)
    );

    logic [ADDR_W-1:0] trn_delta, trn_mag;
    logic              have_free;
    idx_t              free_idx, alloc_idx;
    entry_t            p_ent;

    // training path
    always_comb begin
        st_d      = st_q;
        touch     = 1'b0;
        touch_idx = '0;
        trn_delta = trn_addr - trn_data;
        trn_mag   = trn_delta[ADDR_W-1] ? (~trn_delta + 1'b1) : trn_delta;

        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        alloc_idx = have_free ? free_idx : victim_idx;

        if (trn_valid && !trn_from_pred) begin
            if (t_hit) begin
                if (st_q.ent[t_idx].delta == trn_delta) begin
                    st_d.ent[t_idx].conf = conf_inc(st_q.ent[t_idx].conf);
                end else begin
                    st_d.ent[t_idx].delta = trn_delta;
                    st_d.ent[t_idx].conf  = '0;
                end
                touch     = 1'b1;
                touch_idx = t_idx;
            end else if (trn_mag <= DELTA_MAX) begin
                st_d.ent[alloc_idx].vld   = 1'b1;
                st_d.ent[alloc_idx].tag   = trn_pc;
                st_d.ent[alloc_idx].delta = trn_delta;
                st_d.ent[alloc_idx].conf  = '0;
                touch     = 1'b1;
                touch_idx = alloc_idx;
            end
        end
    end

    // lookup path
    always_comb begin
        p_ent     = st_q.ent[p_idx];
        prd_valid = prd_req && prd_long_miss && prd_runahead && p_hit
                    && (p_ent.conf >= conf_t'(CONF_THR));
        prd_value = prd_valid ? (prd_addr - p_ent.delta) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/avd_predictor_chk.sv
`timescale 1ns/1ps
module avd_predictor_chk #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int STATE_W = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               trn_valid,
    input logic               trn_from_pred,
    input logic               prd_req,
    input logic               prd_long_miss,
    input logic               prd_runahead,
    input logic               prd_valid,
    input logic [ADDR_W-1:0]  prd_value,
    input logic [ENTRIES-1:0] vld_vec,
    input logic [ENTRIES-1:0] p_hit_vec,
    input logic [STATE_W-1:0] state_flat
);

    // R1
    reset_empties_chk: assert property (@(posedge clk)
        rst |=> (vld_vec == '0));

    // R3
    pred_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        prd_valid |-> (prd_req && prd_long_miss && prd_runahead && ($countones(p_hit_vec) == 1)));

    // R10
    idle_value_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !prd_valid |-> (prd_value == '0));

    // R6
    no_train_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!trn_valid || trn_from_pred) |=> $stable(state_flat));

    // R7
    one_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(vld_vec & ~$past(vld_vec)) <= 1));

    // R7
    no_invalidate_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((vld_vec & $past(vld_vec)) == $past(vld_vec)));

endmodule

bind avd_predictor avd_predictor_chk #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W),
    .STATE_W($bits(st_q))
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .trn_valid    (trn_valid),
    .trn_from_pred(trn_from_pred),
    .prd_req      (prd_req),
    .prd_long_miss(prd_long_miss),
    .prd_runahead (prd_runahead),
    .prd_valid    (prd_valid),
    .prd_value    (prd_value),
    .vld_vec      (vld_vec),
    .p_hit_vec    (p_hit_vec),
    .state_flat   (st_q)
);

// File: tb/sim_avd_predictor.sv
`timescale 1ns/1ps
module sim_avd_predictor;

    localparam int          N   = 16;
    localparam logic [31:0] LIM = 32'h10000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trn_valid = 1'b0, trn_from_pred = 1'b0;
    logic [31:0] trn_pc = '0, trn_addr = '0, trn_data = '0;
    logic        prd_req = 1'b0, prd_long_miss = 1'b0, prd_runahead = 1'b0;
    logic [31:0] prd_pc = '0, prd_addr = '0;
    logic        prd_valid;
    logic [31:0] prd_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    avd_predictor u0 (
        .clk(clk), .rst(rst),
        .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_addr(trn_addr),
        .trn_data(trn_data), .trn_from_pred(trn_from_pred),
        .prd_req(prd_req), .prd_pc(prd_pc), .prd_addr(prd_addr),
        .prd_long_miss(prd_long_miss), .prd_runahead(prd_runahead),
        .prd_valid(prd_valid), .prd_value(prd_value)
    );

    // behavioural reference
    bit          m_vld   [N];
    logic [31:0] m_pc    [N];
    logic [31:0] m_delta [N];
    int          m_conf  [N];
    int          order[$];   // front = most recently touched

    function automatic int find(input logic [31:0] pc);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_pc[i] == pc) return i;
        return -1;
    endfunction

    function automatic void touch(input int k);
        for (int i = 0; i < order.size(); i++) begin
            if (order[i] == k) begin
                order.delete(i);
                break;
            end
        end
        order.push_front(k);
    endfunction

    function automatic void m_reset();
        order.delete();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0;
            order.push_back(i);
        end
    endfunction

    function automatic void m_train();
        logic [31:0] d, mag;
        int k, slot;
        if (!trn_valid || trn_from_pred) return;
        d   = trn_addr - trn_data;
        mag = d[31] ? (32'd0 - d) : d;
        k   = find(trn_pc);
        if (k >= 0) begin
            if (m_delta[k] == d) m_conf[k] = (m_conf[k] >= 3) ? 3 : m_conf[k] + 1;
            else begin
                m_delta[k] = d;
                m_conf[k]  = 0;
            end
            touch(k);
        end else if (mag <= LIM) begin
            slot = -1;
            for (int i = 0; i < N; i++) if (!m_vld[i] && slot < 0) slot = i;
            if (slot < 0) slot = order[order.size() - 1];
            m_vld[slot] = 1'b1; m_pc[slot] = trn_pc;
            m_delta[slot] = d;  m_conf[slot] = 0;
            touch(slot);
        end
    endfunction

    task automatic tick(input string req);
        int k;
        logic        ev;
        logic [31:0] evl;
        #1;
        k   = find(prd_pc);
        ev  = prd_req && prd_long_miss && prd_runahead && (k >= 0) && (m_conf[k] >= 2);
        evl = ev ? (prd_addr - m_delta[k]) : 32'd0;
        checks++;
        if (prd_valid !== ev) begin
            errors++;
            $display("FAIL %s prd_valid actual %0b expected %0b", req, prd_valid, ev);
        end
        checks++;
        if (prd_value !== evl) begin
            errors++;
            $display("FAIL %s prd_value actual %h expected %h", req, prd_value, evl);
        end
        @(posedge clk);
        if (rst) m_reset();
        else m_train();
        @(negedge clk);
    endtask

    task automatic set_trn(input logic v, input logic [31:0] pc, input logic [31:0] a,
                           input logic [31:0] d, input logic fp);
        trn_valid = v; trn_pc = pc; trn_addr = a; trn_data = d; trn_from_pred = fp;
    endtask

    task automatic set_prd(input logic rq, input logic [31:0] pc, input logic [31:0] a,
                           input logic ms, input logic ra);
        prd_req = rq; prd_pc = pc; prd_addr = a; prd_long_miss = ms; prd_runahead = ra;
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] d,
                         input string req);
        set_trn(1'b1, pc, a, d, 1'b0);
        set_prd(1'b0, 32'd0, 32'd0, 1'b0, 1'b0);
        tick(req);
        set_trn(1'b0, 32'd0, 32'd0, 32'd0, 1'b0);
    endtask

    task automatic look(input logic [31:0] pc, input logic [31:0] a, input string req);
        set_prd(1'b1, pc, a, 1'b1, 1'b1);
        tick(req);
        set_prd(1'b0, 32'd0, 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        @(negedge clk);
        rst = 1'b1;
        tick("R1");
        tick("R1");
        rst = 1'b0;
        look(32'h40, 32'h1000, "R1");

        // R4: alloc, then two matching repeats needed
        train(32'h40, 32'h1000, 32'h0F00, "R4");
        look(32'h40, 32'h5000, "R4");
        train(32'h40, 32'h2000, 32'h1F00, "R4");
        look(32'h40, 32'h5000, "R4");
        train(32'h40, 32'h3000, 32'h2F00, "R4");
        look(32'h40, 32'h5000, "R2");
        train(32'h40, 32'h3400, 32'h3300, "R4");
        train(32'h40, 32'h3800, 32'h3700, "R4");
        look(32'h40, 32'h7777, "R2");

        // R3 / R10: qualifier gating
        set_prd(1'b1, 32'h40, 32'h5000, 1'b0, 1'b1); tick("R3");
        set_prd(1'b1, 32'h40, 32'h5000, 1'b1, 1'b0); tick("R3");
        set_prd(1'b0, 32'h40, 32'h5000, 1'b1, 1'b1); tick("R10");
        look(32'h44, 32'h5000, "R3");

        // R6: suppressed training
        set_trn(1'b1, 32'h40, 32'h9000, 32'h1, 1'b1);
        set_prd(1'b1, 32'h40, 32'h6000, 1'b1, 1'b1); tick("R6");
        set_trn(1'b0, 32'h40, 32'h9000, 32'h1, 1'b0); tick("R6");
        set_trn(1'b0, 32'h0, 32'h0, 32'h0, 1'b0);
        look(32'h40, 32'h6000, "R6");

        // R9: same-cycle train with differing gap, lookup sees old table
        set_trn(1'b1, 32'h40, 32'h8000, 32'h7000, 1'b0);
        set_prd(1'b1, 32'h40, 32'h6000, 1'b1, 1'b1); tick("R9");
        set_trn(1'b0, 32'h0, 32'h0, 32'h0, 1'b0);
        look(32'h40, 32'h6000, "R5");
        train(32'h40, 32'h8100, 32'h7100, "R5");
        train(32'h40, 32'h8200, 32'h7200, "R5");
        look(32'h40, 32'h6000, "R5");

        // R2: negative gap
        for (int r = 0; r < 3; r++) train(32'h48, 32'h100 + 32'(r), 32'h300 + 32'(r), "R2");
        look(32'h48, 32'h100, "R2");
        look(32'h48, 32'h0, "R2");

        // R8: magnitude filter boundaries
        for (int r = 0; r < 3; r++) train(32'h50, 32'h20000, 32'h10000, "R8");
        look(32'h50, 32'h20000, "R8");
        for (int r = 0; r < 3; r++) train(32'h54, 32'h20001, 32'h10000, "R8");
        look(32'h54, 32'h20001, "R8");
        for (int r = 0; r < 3; r++) train(32'h58, 32'h10000, 32'h20000, "R8");
        look(32'h58, 32'h10000, "R8");
        for (int r = 0; r < 3; r++) train(32'h5C, 32'h10000, 32'h20001, "R8");
        look(32'h5C, 32'h10000, "R8");

        // R7: fill the table, refresh one entry, force evictions
        rst = 1'b1; tick("R1"); rst = 1'b0;
        look(32'h40, 32'h5000, "R1");
        for (int k = 0; k < 16; k++)
            for (int r = 0; r < 3; r++)
                train(32'h1000 + 32'(k * 4), 32'h9000 + 32'(r * 16), 32'h8F00 + 32'(r * 16), "R7");
        look(32'h1004, 32'hA000, "R7");
        train(32'h1000, 32'h9100, 32'h9000, "R7");
        for (int k = 16; k < 19; k++)
            for (int r = 0; r < 3; r++)
                train(32'h1000 + 32'(k * 4), 32'h9000, 32'h8E00, "R7");
        for (int k = 0; k < 19; k++) look(32'h1000 + 32'(k * 4), 32'hC000, "R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule